// File: doc/BRIEF.md
# Vertical Microprogram Sequencer

This block steps through a small writable control store of 10-bit microwords and turns each one into datapath control strobes. A microword has one of two formats. A transfer word carries three 3-bit codes: a source, a destination and an operation. Each code is decoded into a one-hot strobe group. A jump word picks one condition line, compares it with a stated bit, and supplies a 5-bit target address. A complex datapath step is therefore written as a short run of transfer words, with jump words between them.

The microprogram counter moves to the next address after every transfer word and after every jump that is not taken. It loads the target when the selected condition equals the compare bit. The conditions are a memory wait flag, four instruction-register bits and three accumulator bits. The control store is filled through a write port. The port works both during reset and while the program runs. Each written word takes effect the next time its address is executed.

Top module: `vmicro_ctrl`

## Requirements
- R1: Reset sets the microprogram counter to address 0, so the first word executed after reset is the word at address 0.
- R2: In a transfer word (bit 9 = 0), bits 8:6 hold the source code, bits 5:3 the destination code and bits 2:0 the operation code. Code k (1..7) raises bit k-1 of its strobe group, and code 0 raises no strobe.
- R3: After a transfer word, the next address is the current address plus one.
- R4: In a jump word (bit 9 = 1), bits 8:6 select the condition, bit 5 is the compare value and bits 4:0 are the target. When the selected condition equals the compare value, the next address is the target.
- R5: When the selected condition differs from the compare value, the next address is the current address plus one.
- R6: While a jump word is current, all three strobe groups are zero.
- R7: The condition select maps as follows: 0 is the memory wait flag, 1 to 4 are instruction-register bits 0 to 3, and 5 to 7 are accumulator bits 0 to 2.
- R8: A store write with the enable high is stored at the clock edge. It leaves every other address unchanged. A word being executed in the same cycle as its own overwrite still acts with its old contents.
- R9: While reset is high, all strobes are zero.
- R10: The address wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_wait_i | input | 1 | Memory wait condition |
| ir_cond_i | input | 4 | Instruction-register condition bits |
| ac_cond_i | input | 3 | Accumulator condition bits |
| cs_wr_en_i | input | 1 | Control-store write enable |
| cs_wr_addr_i | input | 5 | Control-store write address |
| cs_wr_data_i | input | 10 | Microword to write |
| src_stb_o | output | 7 | One-hot source strobes |
| dst_stb_o | output | 7 | One-hot destination strobes |
| op_stb_o | output | 7 | One-hot operation strobes |

## Verification
A control-store write can land on the address that is executing in the same cycle. The word at that address may also be a jump that is taken back to itself. The bench provokes this by spinning on a wait loop and overwriting the spinning jump with a transfer word while it executes. It then judges two things: the strobes of that cycle are still quiet, and the new transfer strobes appear only after the old jump has been taken. A second collision puts reset in the same cycle as a running program, and the bench checks that the strobes stay quiet and execution restarts at address 0.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
    localparam int FIELD_W = 3;
    localparam int ADDR_W  = 5;
    localparam int WORD_W  = 1 + 3 * FIELD_W;
    localparam int SEL_W   = FIELD_W;
    localparam int STB_W   = (1 << FIELD_W) - 1;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int COND_N  = 1 << SEL_W;

    typedef enum logic {
        FMT_XFER = 1'b0,
        FMT_JUMP = 1'b1
    } fmt_e;

    typedef struct packed {
        fmt_e               fmt;
        logic [FIELD_W-1:0] src;
        logic [FIELD_W-1:0] dst;
        logic [FIELD_W-1:0] op;
    } xfer_word_t;

    typedef struct packed {
        fmt_e              fmt;
        logic [SEL_W-1:0]  sel;
        logic              cmp;
        logic [ADDR_W-1:0] tgt;
    } jump_word_t;
endpackage

// File: rtl/vmc_store.sv
module vmc_store
    import vmc_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && (wr_addr == ADDR_W'(g))) begin
                mem_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            mem_q[g] <= mem_d[g];
        end
    end

    // read reflects the stored word: a write lands only at the edge
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/vmc_cond.sv
module vmc_cond
    import vmc_pkg::*;
#(
    parameter int IR_W = 4,
    parameter int AC_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             mem_wait,
    input  logic [IR_W-1:0]  ir_bits,
    input  logic [AC_W-1:0]  ac_bits,
    output logic             cond
);
    localparam int RAW_N = 1 + IR_W + AC_W;

    logic [RAW_N-1:0]  raw;
    logic [COND_N-1:0] vec;

    assign raw = {ac_bits, ir_bits, mem_wait};

    for (genvar g = 0; g < COND_N; g++) begin : g_line
        if (g < RAW_N) begin : g_used
            assign vec[g] = raw[g];
        end else begin : g_pad
            assign vec[g] = 1'b0;
        end
    end

    assign cond = vec[sel];
endmodule

// File: rtl/vmc_decode.sv
module vmc_decode
    import vmc_pkg::*;
(
    input  logic              active,
    input  logic [WORD_W-1:0] word,
    output logic [STB_W-1:0]  src_stb,
    output logic [STB_W-1:0]  dst_stb,
    output logic [STB_W-1:0]  op_stb
);
    xfer_word_t xw;
    logic       en;

    assign xw = xfer_word_t'(word);
    assign en = active && (xw.fmt == FMT_XFER);

    for (genvar g = 0; g < STB_W; g++) begin : g_stb
        assign src_stb[g] = en && (xw.src == FIELD_W'(g + 1));
        assign dst_stb[g] = en && (xw.dst == FIELD_W'(g + 1));
        assign op_stb[g]  = en && (xw.op  == FIELD_W'(g + 1));
    end
endmodule

// File: rtl/vmc_seq.sv
module vmc_seq
    import vmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              cond,
    output logic [ADDR_W-1:0] upc
);
    typedef struct packed {
        logic [ADDR_W-1:0] upc;
    } seq_state_t;

    seq_state_t state_d, state_q;
    jump_word_t jw;
    logic       taken;

    assign jw = jump_word_t'(word);

    always_comb begin
        state_d = state_q;
        taken   = (jw.fmt == FMT_JUMP) && (cond == jw.cmp);
        if (taken) begin
            state_d.upc = jw.tgt;
        end else begin
            state_d.upc = state_q.upc + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign upc = state_q.upc;
endmodule

// File: rtl/vmicro_ctrl.sv
module vmicro_ctrl
    import vmc_pkg::*;
#(
    parameter int IR_W = 4,
    parameter int AC_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_wait_i,
    input  logic [IR_W-1:0]   ir_cond_i,
    input  logic [AC_W-1:0]   ac_cond_i,
    input  logic              cs_wr_en_i,
    input  logic [ADDR_W-1:0] cs_wr_addr_i,
    input  logic [WORD_W-1:0] cs_wr_data_i,
    output logic [STB_W-1:0]  src_stb_o,
    output logic [STB_W-1:0]  dst_stb_o,
    output logic [STB_W-1:0]  op_stb_o
);
    logic [ADDR_W-1:0] upc;
    logic [WORD_W-1:0] cur_word;
    logic              cond_hit;
    jump_word_t        cur_jump;

    assign cur_jump = jump_word_t'(cur_word);

    vmc_store u_store (
        .clk     (clk),
        .wr_en   (cs_wr_en_i),
        .wr_addr (cs_wr_addr_i),
        .wr_data (cs_wr_data_i),
        .rd_addr (upc),
        .rd_data (cur_word)
    );

    vmc_cond #(
        .IR_W (IR_W),
        .AC_W (AC_W)
    ) u_cond (
        .sel      (cur_jump.sel),
        .mem_wait (mem_wait_i),
        .ir_bits  (ir_cond_i),
        .ac_bits  (ac_cond_i),
        .cond     (cond_hit)
    );

    vmc_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .word (cur_word),
        .cond (cond_hit),
        .upc  (upc)
    );

    vmc_decode u_dec (
        .active  (!rst),
        .word    (cur_word),
        .src_stb (src_stb_o),
        .dst_stb (dst_stb_o),
        .op_stb  (op_stb_o)
    );
endmodule

// File: rtl/vmc_checker.sv
module vmc_checker
    import vmc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] upc,
    input logic [WORD_W-1:0] word,
    input logic              cond,
    input logic [STB_W-1:0]  src,
    input logic [STB_W-1:0]  dst,
    input logic [STB_W-1:0]  op
);
    jump_word_t jw;
    logic       is_jump;

    assign jw      = jump_word_t'(word);
    assign is_jump = (jw.fmt == FMT_JUMP);

    AST_RESET_PC: assert property (@(posedge clk) rst |=> (upc == '0)); // R1
    AST_RESET_QUIET: assert property (@(posedge clk) rst |-> ((src | dst | op) == '0)); // R9
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(src) && $onehot0(dst) && $onehot0(op))); // R2
    AST_JUMP_QUIET: assert property (@(posedge clk) disable iff (rst)
        is_jump |-> ((src | dst | op) == '0)); // R6
    AST_XFER_STEP: assert property (@(posedge clk) disable iff (rst)
        !is_jump |=> (upc == ADDR_W'($past(upc) + 1'b1))); // R3
    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (is_jump && (cond == jw.cmp)) |=> (upc == $past(jw.tgt))); // R4
    AST_JUMP_FALL: assert property (@(posedge clk) disable iff (rst)
        (is_jump && (cond != jw.cmp)) |=> (upc == ADDR_W'($past(upc) + 1'b1))); // R5
endmodule

bind vmicro_ctrl vmc_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .upc  (upc),
    .word (cur_word),
    .cond (cond_hit),
    .src  (src_stb_o),
    .dst  (dst_stb_o),
    .op   (op_stb_o)
);

// File: tb/vmicro_ctrl_tb.sv
`timescale 1ns/1ps
module vmicro_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_wait = 1'b0;
    logic [3:0] ir_c = '0;
    logic [2:0] ac_c = '0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic [6:0] src_stb, dst_stb, op_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vmicro_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .mem_wait_i   (mem_wait),
        .ir_cond_i    (ir_c),
        .ac_cond_i    (ac_c),
        .cs_wr_en_i   (wr_en),
        .cs_wr_addr_i (wr_addr),
        .cs_wr_data_i (wr_data),
        .src_stb_o    (src_stb),
        .dst_stb_o    (dst_stb),
        .op_stb_o     (op_stb)
    );

    // per-cycle vector: {wait, ir[3:0], ac[2:0], exp_src, exp_dst, exp_op}
    localparam logic [16:0] VEC [20] = '{
        {1'b0, 4'b0000, 3'b000, 3'd1, 3'd2, 3'd3}, // @0 R1 R2
        {1'b1, 4'b0000, 3'b000, 3'd0, 3'd0, 3'd0}, // @1 wait hit R4 R6
        {1'b1, 4'b0000, 3'b000, 3'd0, 3'd0, 3'd0}, // @1 spin R4
        {1'b0, 4'b0000, 3'b000, 3'd0, 3'd0, 3'd0}, // @1 fall R5
        {1'b0, 4'b0000, 3'b000, 3'd2, 3'd3, 3'd0}, // @2 R2 op none
        {1'b0, 4'b0010, 3'b000, 3'd0, 3'd0, 3'd0}, // @3 ir1 hit R7
        {1'b0, 4'b0000, 3'b000, 3'd3, 3'd1, 3'd2}, // @8 R4
        {1'b0, 4'b0000, 3'b100, 3'd0, 3'd0, 3'd0}, // @9 ac2 hit R7
        {1'b0, 4'b0000, 3'b000, 3'd6, 3'd5, 3'd4}, // @31
        {1'b0, 4'b0000, 3'b000, 3'd1, 3'd2, 3'd3}, // @0 wrap R10
        {1'b0, 4'b0000, 3'b000, 3'd0, 3'd0, 3'd0}, // @1 fall R5
        {1'b0, 4'b0000, 3'b000, 3'd2, 3'd3, 3'd0}, // @2 R3
        {1'b0, 4'b1101, 3'b000, 3'd0, 3'd0, 3'd0}, // @3 ir1 low R5
        {1'b0, 4'b0000, 3'b000, 3'd4, 3'd0, 3'd5}, // @4 dst none R2
        {1'b0, 4'b0000, 3'b010, 3'd0, 3'd0, 3'd0}, // @5 ac1 vs 0 R5
        {1'b0, 4'b0000, 3'b000, 3'd7, 3'd7, 3'd7}, // @6 R2
        {1'b0, 4'b0000, 3'b000, 3'd0, 3'd0, 3'd0}, // @7 wait==0 R4
        {1'b0, 4'b0000, 3'b000, 3'd5, 3'd6, 3'd1}, // @30
        {1'b0, 4'b0000, 3'b000, 3'd6, 3'd5, 3'd4}, // @31 R10
        {1'b0, 4'b0000, 3'b000, 3'd1, 3'd2, 3'd3}  // @0 R10
    };

    function automatic logic [9:0] rt(input int s, input int d, input int o);
        return {1'b0, 3'(s), 3'(d), 3'(o)};
    endfunction

    function automatic logic [9:0] bj(input int sel, input int c, input int t);
        return {1'b1, 3'(sel), 1'(c), 5'(t)};
    endfunction

    function automatic logic [6:0] oh(input logic [2:0] c);
        return (c == 3'd0) ? 7'd0 : 7'(7'd1 << (c - 3'd1));
    endfunction

    task automatic chk(input string tag, input logic [2:0] es, input logic [2:0] ed,
                       input logic [2:0] eo);
        logic [20:0] exp_v, act_v;
        exp_v = {oh(es), oh(ed), oh(eo)};
        act_v = {src_stb, dst_stb, op_stb};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act_v, exp_v);
        end
    endtask

    task automatic load(input logic [4:0] a, input logic [9:0] w);
        wr_en = 1'b1; wr_addr = a; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cond(input logic [7:0] v);
        {ac_c, ir_c, mem_wait} = v;
    endtask

    initial begin
        @(negedge clk);
        for (int a = 0; a < 32; a++) load(5'(a), 10'd0);
        load(5'd0, rt(1, 2, 3));
        load(5'd1, bj(0, 1, 1));
        load(5'd2, rt(2, 3, 0));
        load(5'd3, bj(2, 1, 8));
        load(5'd4, rt(4, 0, 5));
        load(5'd5, bj(6, 0, 0));
        load(5'd6, rt(7, 7, 7));
        load(5'd7, bj(0, 0, 30));
        load(5'd8, rt(3, 1, 2));
        load(5'd9, bj(7, 1, 31));
        load(5'd30, rt(5, 6, 1));
        load(5'd31, rt(6, 5, 4));
        #1 chk("R9 quiet in reset", 3'd0, 3'd0, 3'd0);
        @(negedge clk);
        rst = 1'b0;

        // vector walk
        for (int i = 0; i < 20; i++) begin
            {mem_wait, ir_c, ac_c} = VEC[i][16:9];
            #1 chk($sformatf("R2-R7 vector %0d", i), VEC[i][8:6], VEC[i][5:3], VEC[i][2:0]);
            @(negedge clk);
        end

        // collision: overwrite the spinning jump at address 1 while it runs (R8)
        mem_wait = 1'b1;
        wr_en = 1'b1; wr_addr = 5'd1; wr_data = rt(2, 2, 2);
        #1 chk("R8 old word acts in write cycle", 3'd0, 3'd0, 3'd0);
        @(negedge clk);
        wr_en = 1'b0; mem_wait = 1'b0;
        #1 chk("R8 new word after taken jump", 3'd2, 3'd2, 3'd2);
        @(negedge clk);
        #1 chk("R8 R3 neighbour untouched", 3'd2, 3'd3, 3'd0);

        // reset during a running program
        rst = 1'b1;
        #1 chk("R9 quiet on mid-run reset", 3'd0, 3'd0, 3'd0);
        @(negedge clk);
        rst = 1'b0;
        #1 chk("R1 restart at address 0", 3'd1, 3'd2, 3'd3);
        @(negedge clk);

        // condition select sweep (R7): address 5 -> taken marker, address 1 -> fall marker
        rst = 1'b1;
        load(5'd5, rt(1, 1, 1));
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 2; p++) begin
                rst = 1'b1;
                load(5'd0, bj(s, 1, 5));
                rst = 1'b0;
                set_cond((p == 1) ? 8'(8'd1 << s) : ~8'(8'd1 << s));
                #1 chk($sformatf("R6 jump quiet sel %0d", s), 3'd0, 3'd0, 3'd0);
                @(negedge clk);
                if (p == 1) begin
                    #1 chk($sformatf("R7 R4 sel %0d taken", s), 3'd1, 3'd1, 3'd1);
                end else begin
                    #1 chk($sformatf("R7 R5 sel %0d fall", s), 3'd2, 3'd2, 3'd2);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule